// File: doc/BRIEF.md
# Two-Level Row-Hit-First DRAM Request Scheduler

This block sits between the cores of a multi-core cluster and a single-channel DRAM. It decides which request is issued next. Each request names a bank, a row, a column, a direction and the core it came from. On arrival it gets a sequence number and is placed in the queue of its bank. Each bank has its own selection stage. That stage prefers a request that targets the bank's open row, and among requests of equal rank it takes the oldest. A single channel stage then picks one command per cycle from the bank offers. It takes the oldest offer whose bus timing is already met.

The block keeps a model of each bank's open row and drives precharge, activate, read and write commands onto the command bus. The spacing between commands comes from parameterised down-counters. A request leaves its queue when its column command issues. In that same cycle the block presents a completion tag carrying the core ID and the sequence number. Upstream sources see backpressure through a valid/ready handshake that closes when the target bank's queue is full.

Top module: `fr_dram_sched`

## Requirements
- R1: Each bank queue holds QUEUE_DEPTH requests. `req_ready_o` is low exactly when the queue of the bank on `req_bank_i` is full, and other banks still accept. A request presented while `req_ready_o` is low is not taken: it never completes and uses no sequence number.
- R2: Accepted requests receive consecutive sequence numbers, starting at 0 after reset. The number appears in `done_seq_o` when the request completes.
- R3: Within a bank, a request that targets the open row is served before any older request that targets another row.
- R4: Among requests of one bank with the same row-hit status, the oldest is served first.
- R5: The channel stage grants the oldest bank offer whose bus timing is met. An older offer that is blocked by bus timing does not stall a younger offer that is eligible.
- R6: Command encoding on `cmd_o` is 0 none, 1 precharge, 2 activate, 3 read, 4 write. An activate goes only to a closed bank. A precharge goes only to an open bank. A read or write goes only to the row that is open in its bank.
- R7: In a bank, a column command follows an activate by at least T_RCD cycles, and an activate follows a precharge by at least T_RP cycles.
- R8: Consecutive column commands are at least T_CCD cycles apart. A column command whose direction differs from the previous one comes at least T_BURST cycles after it.
- R9: At most one command appears per cycle. `done_valid_o` is high exactly in the cycles that show a read or write, and `done_core_o` and `done_seq_o` identify that request.
- R10: After reset `cmd_o` is 0, `done_valid_o` is low, all banks are closed and all queues accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Target bank queue has room |
| req_bank_i | input | $clog2(NUM_BANKS) | Target bank |
| req_row_i | input | ROW_W | Target row |
| req_col_i | input | COL_W | Target column |
| req_we_i | input | 1 | 1 write, 0 read |
| req_core_i | input | CORE_W | Requesting core |
| cmd_o | output | 3 | Issued command (R6 encoding) |
| cmd_bank_o | output | $clog2(NUM_BANKS) | Bank of issued command |
| cmd_row_o | output | ROW_W | Row of issued command |
| cmd_col_o | output | COL_W | Column of issued command |
| done_valid_o | output | 1 | Column command issued this cycle |
| done_core_o | output | CORE_W | Core of completed request |
| done_seq_o | output | 8 | Sequence number of completed request |

## Verification
The hardest case to reach from the ports is a row hit that overtakes an older miss in the same bank while a second bank's request is held back by a read/write turnaround. The mixed stimulus pushes one request per cycle into two banks. The timing is chosen so that the activate for the first row completes before the younger hit and the older miss are both waiting. The expected completion order, 0,3,2,4,1,5, shows in a single run that both the bank stage and the channel stage reorder requests. A monitor rebuilds the open-row state and the command spacing from `cmd_o` alone. A second sequence fills one bank queue before its first column command can issue, and so exposes the backpressure.

// File: rtl/fr_sched_pkg.sv
package fr_sched_pkg;
  localparam int SEQ_W = 8;
  typedef logic [SEQ_W-1:0] seq_t;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_PRE = 3'd1,
    CMD_ACT = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4
  } dram_cmd_e;

  // wrap-safe age compare: a older than b
  function automatic logic seq_older(input seq_t a, input seq_t b);
    seq_t d;
    d = a - b;
    return d[SEQ_W-1];
  endfunction

  function automatic logic is_col(input dram_cmd_e c);
    return (c == CMD_RD) || (c == CMD_WR);
  endfunction
endpackage

// File: rtl/fr_bank_unit.sv
module fr_bank_unit
  import fr_sched_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ROW_W  = 8,
  parameter int COL_W  = 6,
  parameter int CORE_W = 2,
  parameter int T_RCD  = 3,
  parameter int T_RP   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [ROW_W-1:0]  push_row_i,
  input  logic [COL_W-1:0]  push_col_i,
  input  logic              push_we_i,
  input  logic [CORE_W-1:0] push_core_i,
  input  seq_t              push_seq_i,
  output logic              full_o,
  output logic              open_o,
  output logic              offer_vld_o,
  output dram_cmd_e         offer_cmd_o,
  output seq_t              offer_seq_o,
  output logic [ROW_W-1:0]  offer_row_o,
  output logic [COL_W-1:0]  offer_col_o,
  output logic [CORE_W-1:0] offer_core_o,
  input  logic              grant_i
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int RCD_W = $clog2(T_RCD + 1);
  localparam int RP_W  = $clog2(T_RP + 1);

  logic [DEPTH-1:0]  ent_vld;
  logic [ROW_W-1:0]  ent_row  [DEPTH];
  logic [COL_W-1:0]  ent_col  [DEPTH];
  logic              ent_we   [DEPTH];
  logic [CORE_W-1:0] ent_core [DEPTH];
  seq_t              ent_seq  [DEPTH];

  logic              open_vld;
  logic [ROW_W-1:0]  open_row;
  logic [RCD_W-1:0]  rcd_cnt;
  logic [RP_W-1:0]   rp_cnt;

  logic             hit_any, old_any;
  logic [IDX_W-1:0] hit_idx, old_idx, sel_idx, free_idx;
  logic             hit_sel;

  always_comb begin
    hit_any  = 1'b0;
    old_any  = 1'b0;
    hit_idx  = '0;
    old_idx  = '0;
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!ent_vld[i]) free_idx = IDX_W'(i);
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (ent_vld[i]) begin
        if (open_vld && (ent_row[i] == open_row) &&
            (!hit_any || seq_older(ent_seq[i], ent_seq[hit_idx]))) begin
          hit_any = 1'b1;
          hit_idx = IDX_W'(i);
        end
        if (!old_any || seq_older(ent_seq[i], ent_seq[old_idx])) begin
          old_any = 1'b1;
          old_idx = IDX_W'(i);
        end
      end
    end
    hit_sel = hit_any;
    sel_idx = hit_any ? hit_idx : old_idx;
  end

  // bank stage: offer only when bank timing is met
  always_comb begin
    offer_vld_o = 1'b0;
    offer_cmd_o = CMD_NOP;
    if (old_any) begin
      if (hit_sel) begin
        offer_cmd_o = ent_we[sel_idx] ? CMD_WR : CMD_RD;
        offer_vld_o = (rcd_cnt == '0);
      end else if (open_vld) begin
        offer_cmd_o = CMD_PRE;
        offer_vld_o = (rcd_cnt == '0);
      end else begin
        offer_cmd_o = CMD_ACT;
        offer_vld_o = (rp_cnt == '0);
      end
    end
  end

  assign offer_seq_o  = ent_seq[sel_idx];
  assign offer_row_o  = ent_row[sel_idx];
  assign offer_col_o  = ent_col[sel_idx];
  assign offer_core_o = ent_core[sel_idx];
  assign full_o       = &ent_vld;
  assign open_o       = open_vld;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_vld  <= '0;
      open_vld <= 1'b0;
      open_row <= '0;
      rcd_cnt  <= '0;
      rp_cnt   <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        ent_row[i]  <= '0;
        ent_col[i]  <= '0;
        ent_we[i]   <= 1'b0;
        ent_core[i] <= '0;
        ent_seq[i]  <= '0;
      end
    end else begin
      if (grant_i && offer_cmd_o == CMD_ACT) rcd_cnt <= RCD_W'(T_RCD - 1);
      else if (rcd_cnt != '0)                rcd_cnt <= rcd_cnt - 1'b1;
      if (grant_i && offer_cmd_o == CMD_PRE) rp_cnt <= RP_W'(T_RP - 1);
      else if (rp_cnt != '0)                 rp_cnt <= rp_cnt - 1'b1;

      if (grant_i) begin
        unique case (offer_cmd_o)
          CMD_PRE: open_vld <= 1'b0;
          CMD_ACT: begin
            open_vld <= 1'b1;
            open_row <= ent_row[sel_idx];
          end
          CMD_RD, CMD_WR: ent_vld[sel_idx] <= 1'b0;
          default: ;
        endcase
      end
      // free slot is never the popped slot
      if (push_i) begin
        ent_vld[free_idx]  <= 1'b1;
        ent_row[free_idx]  <= push_row_i;
        ent_col[free_idx]  <= push_col_i;
        ent_we[free_idx]   <= push_we_i;
        ent_core[free_idx] <= push_core_i;
        ent_seq[free_idx]  <= push_seq_i;
      end
    end
  end
endmodule

// File: rtl/fr_channel_arb.sv
module fr_channel_arb
  import fr_sched_pkg::*;
#(
  parameter int NB      = 4,
  parameter int T_CCD   = 2,
  parameter int T_BURST = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic      [NB-1:0]    offer_vld_i,
  input  dram_cmd_e [NB-1:0]    offer_cmd_i,
  input  seq_t      [NB-1:0]    offer_seq_i,
  output logic      [NB-1:0]    grant_o
);
  localparam int BANK_W = $clog2(NB);
  localparam int CCD_W  = $clog2(T_CCD + 1);
  localparam int BST_W  = $clog2(T_BURST + 1);

  logic [CCD_W-1:0]  ccd_cnt;
  logic [BST_W-1:0]  bst_cnt;
  logic              last_wr;
  logic              best_ok, elig, col_go, col_wr;
  logic [BANK_W-1:0] best_idx;

  always_comb begin
    best_ok  = 1'b0;
    best_idx = '0;
    grant_o  = '0;
    for (int b = 0; b < NB; b++) begin
      if (is_col(offer_cmd_i[b]))
        elig = offer_vld_i[b] && (ccd_cnt == '0) &&
               ((bst_cnt == '0) || ((offer_cmd_i[b] == CMD_WR) == last_wr));
      else
        elig = offer_vld_i[b];
      if (elig && (!best_ok || seq_older(offer_seq_i[b], offer_seq_i[best_idx]))) begin
        best_ok  = 1'b1;
        best_idx = BANK_W'(b);
      end
    end
    if (best_ok) grant_o[best_idx] = 1'b1;
    col_go = best_ok && is_col(offer_cmd_i[best_idx]);
    col_wr = offer_cmd_i[best_idx] == CMD_WR;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ccd_cnt <= '0;
      bst_cnt <= '0;
      last_wr <= 1'b0;
    end else if (col_go) begin
      ccd_cnt <= CCD_W'(T_CCD - 1);
      bst_cnt <= BST_W'(T_BURST - 1);
      last_wr <= col_wr;
    end else begin
      if (ccd_cnt != '0) ccd_cnt <= ccd_cnt - 1'b1;
      if (bst_cnt != '0) bst_cnt <= bst_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/fr_dram_sched.sv
module fr_dram_sched
  import fr_sched_pkg::*;
#(
  parameter int NUM_BANKS   = 4,
  parameter int QUEUE_DEPTH = 4,
  parameter int ROW_W       = 8,
  parameter int COL_W       = 6,
  parameter int CORE_W      = 2,
  parameter int T_RCD       = 3,
  parameter int T_RP        = 3,
  parameter int T_CCD       = 2,
  parameter int T_BURST     = 4,
  localparam int BANK_W     = $clog2(NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic              req_we_i,
  input  logic [CORE_W-1:0] req_core_i,
  output logic [2:0]        cmd_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [ROW_W-1:0]  cmd_row_o,
  output logic [COL_W-1:0]  cmd_col_o,
  output logic              done_valid_o,
  output logic [CORE_W-1:0] done_core_o,
  output logic [SEQ_W-1:0]  done_seq_o
);
  logic [NUM_BANKS-1:0]             bank_full, bank_open, bank_grant, offer_vld;
  dram_cmd_e [NUM_BANKS-1:0]        offer_cmd;
  seq_t [NUM_BANKS-1:0]             offer_seq;
  logic [NUM_BANKS-1:0][ROW_W-1:0]  offer_row;
  logic [NUM_BANKS-1:0][COL_W-1:0]  offer_col;
  logic [NUM_BANKS-1:0][CORE_W-1:0] offer_core;

  seq_t seq_q;
  logic accept;

  assign req_ready_o = !bank_full[req_bank_i];
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     seq_q <= '0;
    else if (accept) seq_q <= seq_q + 1'b1;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    fr_bank_unit #(
      .DEPTH (QUEUE_DEPTH), .ROW_W(ROW_W), .COL_W(COL_W), .CORE_W(CORE_W),
      .T_RCD (T_RCD), .T_RP(T_RP)
    ) i_bank (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .push_i      (accept && (req_bank_i == BANK_W'(b))),
      .push_row_i  (req_row_i),
      .push_col_i  (req_col_i),
      .push_we_i   (req_we_i),
      .push_core_i (req_core_i),
      .push_seq_i  (seq_q),
      .full_o      (bank_full[b]),
      .open_o      (bank_open[b]),
      .offer_vld_o (offer_vld[b]),
      .offer_cmd_o (offer_cmd[b]),
      .offer_seq_o (offer_seq[b]),
      .offer_row_o (offer_row[b]),
      .offer_col_o (offer_col[b]),
      .offer_core_o(offer_core[b]),
      .grant_i     (bank_grant[b])
    );
  end

  fr_channel_arb #(.NB(NUM_BANKS), .T_CCD(T_CCD), .T_BURST(T_BURST)) i_chan (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .offer_vld_i(offer_vld),
    .offer_cmd_i(offer_cmd),
    .offer_seq_i(offer_seq),
    .grant_o    (bank_grant)
  );

  dram_cmd_e         nxt_cmd;
  logic [BANK_W-1:0] nxt_bank;
  logic [ROW_W-1:0]  nxt_row;
  logic [COL_W-1:0]  nxt_col;
  logic [CORE_W-1:0] nxt_core;
  seq_t              nxt_seq;

  always_comb begin
    nxt_cmd  = CMD_NOP;
    nxt_bank = '0;
    nxt_row  = '0;
    nxt_col  = '0;
    nxt_core = '0;
    nxt_seq  = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_grant[b]) begin
        nxt_cmd  = offer_cmd[b];
        nxt_bank = BANK_W'(b);
        nxt_row  = offer_row[b];
        nxt_col  = offer_col[b];
        nxt_core = offer_core[b];
        nxt_seq  = offer_seq[b];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o        <= CMD_NOP;
      cmd_bank_o   <= '0;
      cmd_row_o    <= '0;
      cmd_col_o    <= '0;
      done_valid_o <= 1'b0;
      done_core_o  <= '0;
      done_seq_o   <= '0;
    end else begin
      cmd_o        <= nxt_cmd;
      cmd_bank_o   <= nxt_bank;
      cmd_row_o    <= nxt_row;
      cmd_col_o    <= nxt_col;
      done_valid_o <= is_col(nxt_cmd);
      done_core_o  <= nxt_core;
      done_seq_o   <= nxt_seq;
    end
  end
endmodule

// File: rtl/fr_dram_sched_chk.sv
module fr_dram_sched_chk
  import fr_sched_pkg::*;
#(
  parameter int NB    = 4,
  parameter int T_RCD = 3,
  parameter int T_CCD = 2,
  localparam int BANK_W = $clog2(NB)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        cmd_i,
  input logic [BANK_W-1:0] cmd_bank_i,
  input logic              done_valid_i,
  input logic [NB-1:0]     grant_i,
  input logic [NB-1:0]     open_i
);
  logic          col_now;
  logic [7:0]    ccd_gap;
  logic [7:0]    rcd_gap [NB];
  logic [NB-1:0] open_prev;

  assign col_now = (cmd_i == 3'd3) || (cmd_i == 3'd4);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ccd_gap   <= 8'hff;
      open_prev <= '0;
      for (int b = 0; b < NB; b++) rcd_gap[b] <= 8'hff;
    end else begin
      open_prev <= open_i;
      ccd_gap   <= col_now ? 8'd1 : ((ccd_gap == 8'hff) ? ccd_gap : ccd_gap + 8'd1);
      for (int b = 0; b < NB; b++)
        rcd_gap[b] <= (cmd_i == 3'd2 && cmd_bank_i == BANK_W'(b)) ? 8'd1 :
                      ((rcd_gap[b] == 8'hff) ? rcd_gap[b] : rcd_gap[b] + 8'd1);
    end
  end

  // R9
  one_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_i));

  // R9
  done_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_valid_i == col_now);

  // R8
  ccd_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_now |-> ccd_gap >= 8'(T_CCD));

  // R6
  act_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd2) |-> !open_prev[cmd_bank_i]);

  // R6
  pre_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 3'd1) |-> open_prev[cmd_bank_i]);

  for (genvar b = 0; b < NB; b++) begin : g_rcd
    // R7
    rcd_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (col_now && cmd_bank_i == BANK_W'(b)) |-> rcd_gap[b] >= 8'(T_RCD));
  end
endmodule

bind fr_dram_sched fr_dram_sched_chk #(
  .NB(NUM_BANKS), .T_RCD(T_RCD), .T_CCD(T_CCD)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_i       (cmd_o),
  .cmd_bank_i  (cmd_bank_o),
  .done_valid_i(done_valid_o),
  .grant_i     (bank_grant),
  .open_i      (bank_open)
);

// File: tb/test_fr_dram_sched.sv
module test_fr_dram_sched;
  localparam int T_RCD = 3, T_RP = 3, T_CCD = 2, T_BURST = 4;

  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       req_valid_i = 1'b0, req_ready_o, req_we_i = 1'b0;
  logic [1:0] req_bank_i = '0, req_core_i = '0;
  logic [7:0] req_row_i = '0;
  logic [5:0] req_col_i = '0;
  logic [2:0] cmd_o;
  logic [1:0] cmd_bank_o, done_core_o;
  logic [7:0] cmd_row_o, done_seq_o;
  logic [5:0] cmd_col_o;
  logic       done_valid_o;

  always #10 clk = ~clk;

  fr_dram_sched i_fr_dram_sched (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_bank_i(req_bank_i),
    .req_row_i(req_row_i), .req_col_i(req_col_i), .req_we_i(req_we_i),
    .req_core_i(req_core_i), .cmd_o(cmd_o), .cmd_bank_o(cmd_bank_o),
    .cmd_row_o(cmd_row_o), .cmd_col_o(cmd_col_o), .done_valid_o(done_valid_o),
    .done_core_o(done_core_o), .done_seq_o(done_seq_o)
  );

  // {bank, row, col, we, core} stimulus | {seq, core} expected at this completion slot
  // R3: seq3 (hit, row5) overtakes seq1 (miss). R5: seq3 issues while older seq2 waits on turnaround.
  // R4: seq1 before seq5 on the same row.
  localparam logic [28:0] VEC [6] = '{
    {2'd0, 8'd5, 6'd1, 1'b0, 2'd0, 8'd0, 2'd0},
    {2'd0, 8'd9, 6'd2, 1'b0, 2'd1, 8'd3, 2'd3},
    {2'd1, 8'd3, 6'd3, 1'b1, 2'd2, 8'd2, 2'd2},
    {2'd0, 8'd5, 6'd4, 1'b0, 2'd3, 8'd4, 2'd0},
    {2'd1, 8'd3, 6'd5, 1'b1, 2'd0, 8'd1, 2'd1},
    {2'd0, 8'd9, 6'd6, 1'b0, 2'd1, 8'd5, 2'd1}
  };

  int n_chk = 0, n_fail = 0, cyc = 0, ndone = 0;
  bit finished = 0;
  int log_seq [16];
  int log_core [16];
  bit bm_open [4];
  int bm_row [4], t_pre [4], t_act [4];
  int t_col = -1000;
  bit last_wr = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  initial for (int b = 0; b < 4; b++) begin
    bm_open[b] = 0; bm_row[b] = 0; t_pre[b] = -1000; t_act[b] = -1000;
  end

  // port-level protocol monitor
  always @(negedge clk) if (rst_ni) begin
    case (cmd_o)
      3'd1: begin
        chk(bm_open[cmd_bank_o], "R6 precharge to open bank", 0, 1);
        bm_open[cmd_bank_o] = 0;
        t_pre[cmd_bank_o] = cyc;
      end
      3'd2: begin
        chk(!bm_open[cmd_bank_o], "R6 activate to closed bank", 1, 0);
        chk(cyc - t_pre[cmd_bank_o] >= T_RP, "R7 precharge-to-activate", cyc - t_pre[cmd_bank_o], T_RP);
        bm_open[cmd_bank_o] = 1;
        bm_row[cmd_bank_o] = cmd_row_o;
        t_act[cmd_bank_o] = cyc;
      end
      3'd3, 3'd4: begin
        chk(bm_open[cmd_bank_o] && bm_row[cmd_bank_o] == int'(cmd_row_o), "R6 column to open row",
            cmd_row_o, bm_row[cmd_bank_o]);
        chk(cyc - t_act[cmd_bank_o] >= T_RCD, "R7 activate-to-column", cyc - t_act[cmd_bank_o], T_RCD);
        chk(cyc - t_col >= T_CCD, "R8 column spacing", cyc - t_col, T_CCD);
        if ((cmd_o == 3'd4) != last_wr)
          chk(cyc - t_col >= T_BURST, "R8 turnaround", cyc - t_col, T_BURST);
        chk(done_valid_o, "R9 tag with column", done_valid_o, 1);
        last_wr = (cmd_o == 3'd4);
        t_col = cyc;
        if (ndone < 16) begin
          log_seq[ndone] = done_seq_o;
          log_core[ndone] = done_core_o;
        end
        ndone++;
      end
      default: chk(!done_valid_o, "R9 no tag without column", done_valid_o, 0);
    endcase
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(cmd_o == 3'd0, "R10 cmd idle", cmd_o, 0);
    chk(!done_valid_o, "R10 no tag", done_valid_o, 0);
    chk(req_ready_o, "R10 ready", req_ready_o, 1);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(cmd_o == 3'd0, "R10 closed banks stay idle", cmd_o, 0);

    // mixed two-bank stream, one request per cycle
    for (int i = 0; i < 6; i++) begin
      {req_bank_i, req_row_i, req_col_i, req_we_i, req_core_i} = VEC[i][28:10];
      req_valid_i = 1'b1;
      #1 chk(req_ready_o, "R1 ready with room", req_ready_o, 1);
      @(negedge clk);
    end
    req_valid_i = 1'b0;
    while (ndone < 6) @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      chk(log_seq[i] == int'(VEC[i][9:2]), "R3 R4 R5 R2 completion seq", log_seq[i], VEC[i][9:2]);
      chk(log_core[i] == int'(VEC[i][1:0]), "R9 completion core", log_core[i], VEC[i][1:0]);
    end
    repeat (10) @(negedge clk);

    // R1 fill bank 2 before its first column can issue
    for (int i = 0; i < 4; i++) begin
      req_bank_i = 2'd2; req_row_i = 8'(i + 1); req_col_i = 6'(i); req_we_i = 1'b0;
      req_core_i = 2'd3; req_valid_i = 1'b1;
      @(negedge clk);
    end
    req_valid_i = 1'b0;
    req_bank_i = 2'd3;
    #1 chk(req_ready_o, "R1 other bank accepts", req_ready_o, 1);
    req_bank_i = 2'd2; req_row_i = 8'd7; req_valid_i = 1'b1;
    #1 chk(!req_ready_o, "R1 full bank refuses", req_ready_o, 0);
    @(negedge clk);
    req_valid_i = 1'b0;
    while (ndone < 10) @(negedge clk);
    for (int i = 6; i < 10; i++)
      chk(log_seq[i] == i, "R4 miss-only bank in age order", log_seq[i], i);

    // R1 R2 refused request consumed no sequence number
    req_bank_i = 2'd3; req_row_i = 8'd1; req_core_i = 2'd2; req_we_i = 1'b1; req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    while (ndone < 11) @(negedge clk);
    chk(log_seq[10] == 10, "R1 R2 seq after refusal", log_seq[10], 10);
    chk(log_core[10] == 2, "R9 core after refusal", log_core[10], 2);
    repeat (20) @(negedge clk);
    chk(ndone == 11, "R1 refused request never completes", ndone, 11);
    finish_run();
  end
endmodule